// File: doc/BRIEF.md
# Display Interrupt Status Aggregator

This block collects event sources from two display pipes and from a command-completion source. It holds them in a pending register that a host reads and clears through a simple synchronous register port. Each pipe has a second-level register. Its low half holds sticky event flags, and its high half holds one enable per flag, placed 16 positions above that flag. A pipe raises its pending bit only at the moment that some enabled flag becomes active. The command-completion source raises its own pending bit directly.

The pending bits are qualified by an enable register and a mask register. Any qualified bit drives a registered level interrupt line. A single-cycle message pulse is produced only when the qualified set goes from empty to non-empty. Host software therefore gets exactly one message per transition into the interrupting state, and the level line serves wired interrupt schemes. A status-mask register is present for register compatibility, but it does not affect interrupt generation.

Top module: `disp_irq_agg`

## Requirements
- R1: After reset the pending register reads 0x00000000, the mask register reads 0xFFFFFFFF, the enable register reads 0x00000000, the status-mask register reads 0xFFFFFFFF, both pipe registers read 0x00000000, and irq_o and msi_o are low.
- R2: A high input pipe_evt_i[p*16+i] sets flag i (bit i) of pipe p's register, and the flag stays set. Bits 31:16 of the pipe register are read/write enables, where enable i sits at bit i+16.
- R3: Writing a 1 to a flag position (bits 15:0) of a pipe register clears that flag. Writing a 0 there leaves the flag unchanged.
- R4: The pending bit of pipe p (bit 1+p) is set once, when the set of flags that are both set and enabled goes from empty to non-empty. While that set stays non-empty, no new event and no clear of the pending bit causes the bit to be set again.
- R5: A high user_evt_i sets pending bit 0.
- R6: Writing a 1 to a pending bit clears it. If the same source sets that bit in the same cycle, the bit stays set.
- R7: irq_o is high one cycle after any pending bit is set that is also set in the enable register and clear in the mask register. irq_o is low one cycle after no such bit remains.
- R8: msi_o is a single-cycle pulse. It is given only when the qualified pending set of R7 goes from empty to non-empty, and it coincides with the rising edge of irq_o.
- R9: The status-mask register is read/write and has no effect on irq_o or msi_o.
- R10: When reg_rd is high at a clock edge, reg_rvalid is high and reg_rdata holds the addressed register after that edge. The addresses are 0 pending, 1 mask, 2 enable, 3 status-mask, 4 pipe 0, 5 pipe 1. Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pipe_evt_i | input | 32 | Pipe event flags, pipe p flag i at bit p*16+i |
| user_evt_i | input | 1 | Command-completion event |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after reg_rd |
| reg_rvalid | output | 1 | Read data valid |
| irq_o | output | 1 | Level interrupt |
| msi_o | output | 1 | Message interrupt pulse |

## Verification
A corrupted pipe edge register shows up as a pending bit that is set again after the host clears it. This can be seen on the next read of the pending register, two cycles after the event. A wrong qualification or a wrong message-edge state shows at irq_o, or as an extra or a missing msi_o pulse, one cycle after the pending change. That is why every scenario counts message pulses as well as reading registers. Clear-versus-set races are driven in the same cycle, so a wrong priority shows on the very next read.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
  // register addresses
  localparam int unsigned ADDR_IDENT = 0;
  localparam int unsigned ADDR_MASK  = 1;
  localparam int unsigned ADDR_ENAB  = 2;
  localparam int unsigned ADDR_HSM   = 3;
  localparam int unsigned ADDR_PIPE0 = 4;
  // pending-register bit positions
  localparam int unsigned USER_BIT   = 0;
  localparam int unsigned PIPE_BIT0  = 1;
endpackage

// File: rtl/disp_pipe_stat.sv
module disp_pipe_stat #(
  parameter int DW     = 32,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DW-1:0]     wdata,
  input  logic [STAT_W-1:0] evt_i,
  output logic [DW-1:0]     stat_o,
  output logic              rise_o
);
  localparam int EN_LO = STAT_W;

  logic [STAT_W-1:0] flag_q, en_q, clr;
  logic              hit, hit_q;

  assign clr = wr_en ? wdata[STAT_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      en_q   <= '0;
      hit_q  <= 1'b0;
    end else begin
      flag_q <= (flag_q & ~clr) | evt_i;
      if (wr_en) en_q <= wdata[EN_LO +: STAT_W];
      hit_q  <= hit;
    end
  end

  assign hit    = |(flag_q & en_q);
  assign rise_o = hit & ~hit_q;

  always_comb begin
    stat_o = '0;
    stat_o[STAT_W-1:0]     = flag_q;
    stat_o[EN_LO +: STAT_W] = en_q;
  end

  // R3: a cleared flag with no new event is gone on the next cycle
  assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && evt_i == '0) |=> ((flag_q & $past(wdata[STAT_W-1:0])) == '0));
  // R4: a rising edge is one cycle wide
  assert_edge_once_R4: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
  // R2: an event flag is set in the following cycle
  assert_flag_set_R2: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));
endmodule

// File: rtl/disp_irq_core.sv
module disp_irq_core #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] set_i,
  input  logic          wr_ident,
  input  logic          wr_mask,
  input  logic          wr_enab,
  input  logic          wr_hsm,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ident_o,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] enab_o,
  output logic [DW-1:0] hsm_o,
  output logic          irq_o,
  output logic          msi_o
);
  logic [DW-1:0] ident_q, mask_q, enab_q, hsm_q, clr;
  logic          any_act, irq_q, msi_q;

  assign clr     = wr_ident ? wdata : '0;
  assign any_act = |(ident_q & enab_q & ~mask_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ident_q <= '0;
      mask_q  <= '1;
      enab_q  <= '0;
      hsm_q   <= '1;
      irq_q   <= 1'b0;
      msi_q   <= 1'b0;
    end else begin
      ident_q <= (ident_q & ~clr) | set_i;
      if (wr_mask) mask_q <= wdata;
      if (wr_enab) enab_q <= wdata;
      if (wr_hsm)  hsm_q  <= wdata;
      irq_q   <= any_act;
      msi_q   <= any_act & ~irq_q;
    end
  end

  assign ident_o = ident_q;
  assign mask_o  = mask_q;
  assign enab_o  = enab_q;
  assign hsm_o   = hsm_q;
  assign irq_o   = irq_q;
  assign msi_o   = msi_q;

  // R1: reset values visible on the first cycle after reset
  assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == '1 && enab_q == '0 && ident_q == '0 && !irq_q));
  // R6: a set source wins over a same-cycle clear
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((ident_q & $past(set_i)) == $past(set_i)));
  // R8: message is a single pulse
  assert_msi_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    msi_o |=> !msi_o);
  // R8: message coincides with rising edge of the level line
  assert_msi_edge_R8: assert property (@(posedge clk) disable iff (rst)
    msi_o |-> (irq_o && !$past(irq_o)));
  // R7: a qualified pending bit raises the level line
  assert_irq_level_R7: assert property (@(posedge clk) disable iff (rst)
    (|(ident_q & enab_q & ~mask_q)) |=> irq_o);
endmodule

// File: rtl/disp_irq_agg.sv
module disp_irq_agg
  import disp_irq_pkg::*;
#(
  parameter int DW        = 32,
  parameter int AW        = 3,
  parameter int STAT_W    = 16,
  parameter int NUM_PIPES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PIPES*STAT_W-1:0] pipe_evt_i,
  input  logic                        user_evt_i,
  input  logic                        reg_wr,
  input  logic                        reg_rd,
  input  logic [AW-1:0]               reg_addr,
  input  logic [DW-1:0]               reg_wdata,
  output logic [DW-1:0]               reg_rdata,
  output logic                        reg_rvalid,
  output logic                        irq_o,
  output logic                        msi_o
);
  logic [NUM_PIPES-1:0]   pipe_rise;
  logic [DW-1:0]          pipe_stat [NUM_PIPES];
  logic [NUM_PIPES-1:0]   pipe_wr;
  logic [DW-1:0]          set_vec, ident, mask, enab, hsm, rd_mux;
  logic [DW-1:0]          rdata_q;
  logic                   rvalid_q;

  function automatic logic hit_addr(input logic [AW-1:0] a, input int unsigned v);
    return a == AW'(v);
  endfunction

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    assign pipe_wr[p] = reg_wr && hit_addr(reg_addr, ADDR_PIPE0 + p);
    disp_pipe_stat #(.DW(DW), .STAT_W(STAT_W)) u_stat (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (pipe_wr[p]),
      .wdata  (reg_wdata),
      .evt_i  (pipe_evt_i[p*STAT_W +: STAT_W]),
      .stat_o (pipe_stat[p]),
      .rise_o (pipe_rise[p])
    );
  end

  always_comb begin
    set_vec = '0;
    set_vec[USER_BIT] = user_evt_i;
    for (int p = 0; p < NUM_PIPES; p++) set_vec[PIPE_BIT0 + p] = pipe_rise[p];
  end

  disp_irq_core #(.DW(DW)) u_core (
    .clk      (clk),
    .rst      (rst),
    .set_i    (set_vec),
    .wr_ident (reg_wr && hit_addr(reg_addr, ADDR_IDENT)),
    .wr_mask  (reg_wr && hit_addr(reg_addr, ADDR_MASK)),
    .wr_enab  (reg_wr && hit_addr(reg_addr, ADDR_ENAB)),
    .wr_hsm   (reg_wr && hit_addr(reg_addr, ADDR_HSM)),
    .wdata    (reg_wdata),
    .ident_o  (ident),
    .mask_o   (mask),
    .enab_o   (enab),
    .hsm_o    (hsm),
    .irq_o    (irq_o),
    .msi_o    (msi_o)
  );

  always_comb begin
    rd_mux = '0;
    if (hit_addr(reg_addr, ADDR_IDENT)) rd_mux = ident;
    if (hit_addr(reg_addr, ADDR_MASK))  rd_mux = mask;
    if (hit_addr(reg_addr, ADDR_ENAB))  rd_mux = enab;
    if (hit_addr(reg_addr, ADDR_HSM))   rd_mux = hsm;
    for (int p = 0; p < NUM_PIPES; p++)
      if (hit_addr(reg_addr, ADDR_PIPE0 + p)) rd_mux = pipe_stat[p];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= reg_rd;
      if (reg_rd) rdata_q <= rd_mux;
    end
  end

  assign reg_rdata  = rdata_q;
  assign reg_rvalid = rvalid_q;

  // R10: one-cycle read latency
  assert_read_lat_R10: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid);
  assert_no_spur_R10: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> !reg_rvalid);
endmodule

// File: tb/tb_disp_irq_agg.sv
module tb_disp_irq_agg;
  logic        clk = 0, rst = 1;
  logic [31:0] pipe_evt = '0;
  logic        user_evt = 0, wr = 0, rd = 0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        rvalid, irq, msi;
  int          n_chk = 0, n_fail = 0, msi_cnt = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  disp_irq_agg dut (
    .clk(clk), .rst(rst), .pipe_evt_i(pipe_evt), .user_evt_i(user_evt),
    .reg_wr(wr), .reg_rd(rd), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .reg_rvalid(rvalid), .irq_o(irq), .msi_o(msi));

  always @(negedge clk) if (!rst && msi) msi_cnt++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1; addr = a;
    @(negedge clk); rd = 0;
    check("R10 rvalid", {31'b0, rvalid}, 32'd1);
    d = rdata;
  endtask

  task automatic pipe_pulse(input int p, input int i);
    @(negedge clk); pipe_evt[p*16+i] = 1;
    @(negedge clk); pipe_evt = '0;
  endtask

  task automatic user_pulse();
    @(negedge clk); user_evt = 1;
    @(negedge clk); user_evt = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 msi", {31'b0, msi}, 0);
    check("R10 idle rvalid", {31'b0, rvalid}, 0);
    reg_read(0, v); check("R1 pending", v, 32'h0);
    reg_read(1, v); check("R1 mask", v, 32'hFFFF_FFFF);
    reg_read(2, v); check("R1 enable", v, 32'h0);
    reg_read(3, v); check("R1 status-mask", v, 32'hFFFF_FFFF);
    reg_read(4, v); check("R1 pipe0", v, 32'h0);
    reg_read(5, v); check("R1 pipe1", v, 32'h0);
    reg_read(7, v); check("R10 unused addr", v, 32'h0);
  endtask

  task automatic t_pipe_status();
    logic [31:0] v;
    reg_write(4, 32'h0008_0000);
    pipe_pulse(0, 3); pipe_pulse(0, 5);
    reg_read(4, v); check("R2 flags and enable", v, 32'h0008_0028);
    reg_write(4, 32'h0008_0020);
    reg_read(4, v); check("R3 w1c flag5", v, 32'h0008_0008);
    reg_write(4, 32'h0008_0000);
    reg_read(4, v); check("R3 write zero keeps", v, 32'h0008_0008);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    reg_read(0, v); check("R4 pipe0 pending", v, 32'h2);
    reg_write(0, 32'h2);
    idle(3);
    reg_read(0, v); check("R4 no re-set while held", v, 32'h0);
    pipe_pulse(0, 3); idle(2);
    reg_read(0, v); check("R4 repeat event no re-set", v, 32'h0);
    reg_write(4, 32'h0008_0008);
    idle(2);
    pipe_pulse(0, 3); idle(2);
    reg_read(0, v); check("R4 new edge sets", v, 32'h2);
    pipe_pulse(0, 7); idle(2);
    reg_write(0, 32'h2); idle(2);
    reg_read(0, v); check("R4 disabled flag ignored", v, 32'h0);
    reg_write(4, 32'h0000_00FF);
  endtask

  task automatic t_user();
    logic [31:0] v;
    user_pulse(); idle(1);
    reg_read(0, v); check("R5 user pending", v, 32'h1);
    reg_write(0, 32'h1);
    reg_read(0, v); check("R6 pending w1c", v, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    reg_write(2, 32'h7);
    reg_write(1, ~32'h7);
    idle(2);
    msi_cnt = 0;
    check("R7 irq idle", {31'b0, irq}, 0);
    user_pulse(); idle(2);
    check("R7 irq on user", {31'b0, irq}, 1);
    check("R8 one msi", msi_cnt, 1);
    reg_write(5, 32'h0001_0000);
    pipe_pulse(1, 0); idle(3);
    reg_read(0, v); check("R4 pipe1 pending", v, 32'h5);
    check("R8 no msi while busy", msi_cnt, 1);
    reg_write(0, 32'h1); idle(2);
    check("R7 irq held by pipe1", {31'b0, irq}, 1);
    reg_write(0, 32'h4); idle(2);
    check("R7 irq drops", {31'b0, irq}, 0);
    user_pulse(); idle(2);
    check("R8 second msi", msi_cnt, 2);
    reg_write(0, 32'h1); idle(2);
    reg_write(1, ~32'h6);
    user_pulse(); idle(3);
    check("R7 masked no irq", {31'b0, irq}, 0);
    reg_read(0, v); check("R7 masked still pending", v, 32'h1);
    reg_write(2, 32'h6); reg_write(1, ~32'h7); idle(3);
    check("R7 not enabled no irq", {31'b0, irq}, 0);
    reg_write(2, 32'h7); idle(2);
    check("R7 enable raises irq", {31'b0, irq}, 1);
    check("R8 third msi", msi_cnt, 3);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    @(negedge clk); wr = 1; addr = 0; wdata = 32'h1; user_evt = 1;
    @(negedge clk); wr = 0; user_evt = 0;
    reg_read(0, v); check("R6 set wins", v, 32'h1);
  endtask

  task automatic t_hsm();
    logic [31:0] v;
    reg_write(3, 32'h0);
    reg_read(3, v); check("R9 status-mask rw", v, 32'h0);
    idle(2);
    check("R9 irq unaffected", {31'b0, irq}, 1);
    check("R9 no msi", msi_cnt, 3);
    reg_write(0, 32'h1); idle(2);
    check("R9 irq clears", {31'b0, irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_pipe_status();
    t_edge();
    t_user();
    t_irq();
    t_set_wins();
    t_hsm();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule